// File: doc/BRIEF.md
# Integer Add/Subtract Flag and Address Unit

A purely combinational execution slice for a 64-bit processor that also runs a 32-bit operand mode. For each operation it forms one integer sum, which can be a plain add, a subtract, a carry-chained add or subtract, a negation or a comparison. From that sum it derives the result and the four condition flags: negative, zero, carry and overflow. The same slice also forms program-counter-relative addresses, either at byte granularity or at 4 KiB page granularity.

Decode, the register file and operand shifting or extension all sit upstream of this unit. The unit receives an opcode, a width select, a flag-update select, two operands, the current flags, the program counter and an immediate. It returns the result, a destination write enable and the next value of the flags.

Opcode encoding on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | subtract |
| 2 | add with carry |
| 3 | subtract with carry |
| 4 | negate |
| 5 | negate with carry |
| 6 | compare |
| 7 | compare negative |
| 8 | byte-relative address |
| 9 | page-relative address |
| 10 to 15 | reserved |

The flags vector is ordered {N, Z, C, V}, so bit 3 is N and bit 0 is V.

Top module: `asu_core`

## Requirements
- R1: Code 0 returns rn + op2. Code 2 returns rn + op2 + C, where C is `flags_i[1]`.
- R2: Code 1 returns rn - op2. Code 3 returns rn + ~op2 + C.
- R3: Code 4 returns 0 - op2. Code 5 returns ~op2 + C.
- R4: Code 6 (rn - op2) and code 7 (rn + op2) keep `wr_en_o` low and drive `res_o` to 0. They always write the flags, whatever the value of `set_flags_i`.
- R5: With `wide_i`=0, all arithmetic works on bits 31:0, carry and overflow come from bit 31, and `res_o[63:32]` is 0.
- R6: When the flags are written, they are set as follows:
  - N is the sign bit of the result at the active width.
  - Z is 1 exactly when the result at that width is zero.
  - C is the carry out of the addition actually performed, so after a subtraction C=1 means no borrow.
  - V is signed overflow.
- R7: For codes 0 to 5, `flags_o` equals `flags_i` when `set_flags_i`=0.
- R8: Code 8 returns pc + sign-extended `imm_i[20:0]`. `wide_i` and `set_flags_i` are ignored, and the flags are left unchanged.
- R9: Code 9 returns pc with bits 11:0 cleared, plus sign-extended `imm_i[32:12]` shifted left by 12. `imm_i[11:0]` is ignored, and the flags are left unchanged.
- R10: Codes 10 to 15 give `wr_en_o`=0 and `res_o`=0, and leave the flags unchanged.
- R11: `wr_en_o` is 1 for codes 0 to 5 and for codes 8 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 64-bit, 0 = 32-bit operands |
| set_flags_i | input | 1 | Write flags for codes 0 to 5 |
| rn_i | input | 64 | First operand |
| op2_i | input | 64 | Second operand |
| flags_i | input | 4 | Current {N,Z,C,V} |
| pc_i | input | 64 | Program counter |
| imm_i | input | 33 | Address offset immediate |
| res_o | output | 64 | Result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next {N,Z,C,V} |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath, a 32-bit narrow mode, a 21-bit byte offset and a 33-bit page offset with a 12-bit page shift. These values put both carry positions (bit 31 and bit 63) within reach of directed edge operands such as all-ones plus one and the most positive value plus one. They also allow page arithmetic that crosses the sign of the offset. Random operands with all flag inputs set or clear then exercise the carry-chained forms against a behavioural model built on wide signed and unsigned integers.

// File: rtl/asu_pkg.sv
package asu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SBC  = 4'd3,
    OP_NEG  = 4'd4,
    OP_NGC  = 4'd5,
    OP_CMP  = 4'd6,
    OP_CMN  = 4'd7,
    OP_ADR  = 4'd8,
    OP_ADRP = 4'd9
  } asu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } asu_flags_t;
endpackage

// File: rtl/asu_opsel.sv
module asu_opsel
  import asu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] rn_i,
  input  logic [XLEN-1:0] op2_i,
  input  logic            c_flag_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  output logic            cin_o,
  output logic            is_arith_o,
  output logic            is_cmp_o,
  output logic            is_addr_o,
  output logic            is_page_o
);
  logic sub_path, zero_a;

  always_comb begin
    sub_path   = 1'b0;
    zero_a     = 1'b0;
    cin_o      = 1'b0;
    is_arith_o = 1'b1;
    is_cmp_o   = 1'b0;
    is_addr_o  = 1'b0;
    is_page_o  = 1'b0;
    unique case (op_i)
      OP_ADD:  ;
      OP_ADC:  cin_o = c_flag_i;
      OP_SUB:  begin sub_path = 1'b1; cin_o = 1'b1; end
      OP_SBC:  begin sub_path = 1'b1; cin_o = c_flag_i; end
      OP_NEG:  begin sub_path = 1'b1; zero_a = 1'b1; cin_o = 1'b1; end
      OP_NGC:  begin sub_path = 1'b1; zero_a = 1'b1; cin_o = c_flag_i; end
      OP_CMP:  begin sub_path = 1'b1; cin_o = 1'b1; is_cmp_o = 1'b1; end
      OP_CMN:  is_cmp_o = 1'b1;
      OP_ADR:  begin is_arith_o = 1'b0; is_addr_o = 1'b1; end
      OP_ADRP: begin is_arith_o = 1'b0; is_addr_o = 1'b1; is_page_o = 1'b1; end
      default: is_arith_o = 1'b0;
    endcase
  end

  // subtraction is addition of the inverted operand plus carry-in
  assign a_o = zero_a   ? '0     : rn_i;
  assign b_o = sub_path ? ~op2_i : op2_i;
endmodule

// File: rtl/asu_adder.sv
module asu_adder #(
  parameter int XLEN = 64,
  parameter int NLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            cin_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] sum_o,
  output logic            n_o,
  output logic            z_o,
  output logic            c_o,
  output logic            v_o
);
  localparam int HI_W = XLEN - NLEN;

  logic [XLEN:0] full_sum;
  logic [NLEN:0] nar_sum;
  logic          sa, sb, sr;

  assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, cin_i};
  assign nar_sum  = {1'b0, a_i[NLEN-1:0]} + {1'b0, b_i[NLEN-1:0]} + {{NLEN{1'b0}}, cin_i};

  assign sum_o = wide_i ? full_sum[XLEN-1:0] : {{HI_W{1'b0}}, nar_sum[NLEN-1:0]};
  assign sa    = wide_i ? a_i[XLEN-1] : a_i[NLEN-1];
  assign sb    = wide_i ? b_i[XLEN-1] : b_i[NLEN-1];
  assign sr    = wide_i ? full_sum[XLEN-1] : nar_sum[NLEN-1];

  assign n_o = sr;
  assign z_o = (sum_o == '0);
  assign c_o = wide_i ? full_sum[XLEN] : nar_sum[NLEN];
  assign v_o = (sa == sb) && (sr != sa);
endmodule

// File: rtl/asu_addr_gen.sv
module asu_addr_gen #(
  parameter int XLEN     = 64,
  parameter int ADR_W    = 21,
  parameter int PG_W     = 33,
  parameter int PG_SHIFT = 12
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [PG_W-1:0] imm_i,
  input  logic            page_i,
  output logic [XLEN-1:0] addr_o
);
  logic [XLEN-1:0] off_byte, off_page, base;

  assign off_byte = {{(XLEN-ADR_W){imm_i[ADR_W-1]}}, imm_i[ADR_W-1:0]};
  assign off_page = {{(XLEN-PG_W){imm_i[PG_W-1]}}, imm_i[PG_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign base     = page_i ? {pc_i[XLEN-1:PG_SHIFT], {PG_SHIFT{1'b0}}} : pc_i;
  assign addr_o   = base + (page_i ? off_page : off_byte);
endmodule

// File: rtl/asu_core.sv
module asu_core
  import asu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NLEN     = 32,
  parameter int ADR_W    = 21,
  parameter int PG_W     = 33,
  parameter int PG_SHIFT = 12
) (
  input  logic [3:0]      op_i,
  input  logic            wide_i,
  input  logic            set_flags_i,
  input  logic [XLEN-1:0] rn_i,
  input  logic [XLEN-1:0] op2_i,
  input  logic [3:0]      flags_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [PG_W-1:0] imm_i,
  output logic [XLEN-1:0] res_o,
  output logic            wr_en_o,
  output logic [3:0]      flags_o
);
  asu_flags_t      fl_in, fl_new;
  logic [XLEN-1:0] a, b, sum, addr;
  logic            cin, is_arith, is_cmp, is_addr, is_page, upd_flags;

  assign fl_in = asu_flags_t'(flags_i);

  asu_opsel #(.XLEN(XLEN)) u_opsel (
    .op_i(op_i), .rn_i(rn_i), .op2_i(op2_i), .c_flag_i(fl_in.c),
    .a_o(a), .b_o(b), .cin_o(cin),
    .is_arith_o(is_arith), .is_cmp_o(is_cmp), .is_addr_o(is_addr), .is_page_o(is_page)
  );

  asu_adder #(.XLEN(XLEN), .NLEN(NLEN)) u_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .wide_i(wide_i), .sum_o(sum),
    .n_o(fl_new.n), .z_o(fl_new.z), .c_o(fl_new.c), .v_o(fl_new.v)
  );

  asu_addr_gen #(.XLEN(XLEN), .ADR_W(ADR_W), .PG_W(PG_W), .PG_SHIFT(PG_SHIFT)) u_addr (
    .pc_i(pc_i), .imm_i(imm_i), .page_i(is_page), .addr_o(addr)
  );

  // compares always write flags
  assign upd_flags = is_arith && (set_flags_i || is_cmp);
  assign wr_en_o   = (is_arith && !is_cmp) || is_addr;
  assign flags_o   = upd_flags ? fl_new : fl_in;

  always_comb begin
    if (is_addr)                  res_o = addr;
    else if (is_arith && !is_cmp) res_o = sum;
    else                          res_o = '0;
  end

  always_comb begin
    AST_CMP_NO_WRITE: assert (!(op_i inside {OP_CMP, OP_CMN}) || (!wr_en_o && res_o == '0))
      else $error("compare wrote a result"); // R4
    AST_NARROW_ZEXT: assert (wide_i || is_addr || res_o[XLEN-1:NLEN] == '0)
      else $error("narrow result not zero-extended"); // R5
    AST_Z_TRACKS_RES: assert (!(upd_flags && wr_en_o) || (flags_o[2] == (res_o == '0)))
      else $error("Z disagrees with result"); // R6
    AST_FLAGS_HOLD: assert (set_flags_i || !(op_i inside {[4'd0:4'd5]}) || flags_o == flags_i)
      else $error("flags changed without update"); // R7
    AST_PAGE_ALIGN: assert (op_i != OP_ADRP || res_o[PG_SHIFT-1:0] == '0)
      else $error("page address not aligned"); // R9
    AST_RSVD_IDLE: assert (op_i < 4'd10 || (!wr_en_o && flags_o == flags_i))
      else $error("reserved code had an effect"); // R10
  end
endmodule

// File: tb/asu_core_bench.sv
module asu_core_bench;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic        wide, sf;
  logic [63:0] rn, op2, pc;
  logic [3:0]  fl;
  logic [32:0] imm;
  logic [63:0] res;
  logic        we;
  logic [3:0]  flo;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  asu_core u_asu_core (
    .op_i(op), .wide_i(wide), .set_flags_i(sf), .rn_i(rn), .op2_i(op2),
    .flags_i(fl), .pc_i(pc), .imm_i(imm), .res_o(res), .wr_en_o(we), .flags_o(flo)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd2: return "R1";
      4'd1, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6, 4'd7: return "R4";
      4'd8:       return "R8";
      4'd9:       return "R9";
      default:    return "R10";
    endcase
  endfunction

  // behavioural model on wide integers
  task automatic model(output logic [63:0] e_res, output logic e_we, output logic [3:0] e_fl);
    int          w;
    logic [65:0] ua, ub, us, modv;
    logic signed [65:0] sa, sb, ss, lim;
    logic        cin, sub, zero_a, cmp;
    logic [63:0] r, page_base;
    e_res = 64'd0; e_we = 1'b0; e_fl = fl;
    if (op == 4'd8) begin
      e_res = pc + 64'($signed(imm[20:0])); e_we = 1'b1; return;
    end
    if (op == 4'd9) begin
      page_base = pc & ~64'hFFF;
      e_res = page_base + (64'($signed(imm[32:12])) * 64'd4096); e_we = 1'b1; return;
    end
    if (op > 4'd7) return;
    w = wide ? 64 : 32;
    modv = 66'd1 << w;
    sub = op inside {4'd1, 4'd3, 4'd4, 4'd5, 4'd6};
    zero_a = op inside {4'd4, 4'd5};
    cmp = op inside {4'd6, 4'd7};
    cin = (op inside {4'd2, 4'd3, 4'd5}) ? fl[1] : (op inside {4'd1, 4'd4, 4'd6});
    ua = zero_a ? 66'd0 : (wide ? {2'b0, rn} : {34'b0, rn[31:0]});
    ub = wide ? {2'b0, op2} : {34'b0, op2[31:0]};
    sa = zero_a ? 66'sd0 : (wide ? $signed({{2{rn[63]}}, rn}) : $signed({{34{rn[31]}}, rn[31:0]}));
    sb = wide ? $signed({{2{op2[63]}}, op2}) : $signed({{34{op2[31]}}, op2[31:0]});
    if (sub) begin
      us = ua + (modv - 66'd1 - ub) + 66'(cin);
      ss = sa - sb - 66'sd1 + $signed({65'd0, cin});
    end else begin
      us = ua + ub + 66'(cin);
      ss = sa + sb + $signed({65'd0, cin});
    end
    r = 64'(us % modv);
    lim = $signed(66'd1 << (w - 1));
    if (!cmp) begin e_res = r; e_we = 1'b1; end
    if (sf || cmp)
      e_fl = {r[w-1], r == 64'd0, us >= modv, (ss >= lim) || (ss < -lim)};
  endtask

  task automatic check(input string note);
    logic [63:0] e_res; logic e_we; logic [3:0] e_fl; string t;
    model(e_res, e_we, e_fl);
    t = tag_of(op);
    n_tests += 3;
    if (res !== e_res) begin n_fail++;
      $display("FAIL %s res %s op=%0d act=%h exp=%h", t, note, op, res, e_res); end
    if (we !== e_we) begin n_fail++;
      $display("FAIL %s/R11 wr_en %s op=%0d act=%b exp=%b", t, note, op, we, e_we); end
    if (flo !== e_fl) begin n_fail++;
      $display("FAIL %s/R6 flags %s op=%0d act=%b exp=%b", t, note, op, flo, e_fl); end
  endtask

  task automatic run(input logic [3:0] o, input logic wd, input logic s, input logic [63:0] a,
                     input logic [63:0] b, input logic [3:0] f, input logic [63:0] p,
                     input logic [32:0] i, input string note);
    @(posedge clk);
    op = o; wide = wd; sf = s; rn = a; op2 = b; fl = f; pc = p; imm = i;
    @(negedge clk);
    check(note);
  endtask

  initial begin
    op = 4'd0; wide = 1'b1; sf = 1'b0; rn = '0; op2 = '0; fl = 4'b0000; pc = '0; imm = '0;
    @(negedge clk);
    check("idle state R1");
    // R1 carry out of bit 63 and signed overflow
    run(4'd0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'b0000, 0, 0, "R1 wrap");
    run(4'd0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 4'b0000, 0, 0, "R1 ovf");
    run(4'd2, 1, 1, 64'd5, 64'd6, 4'b0010, 0, 0, "R1 adc c=1");
    // R2 equal operands, borrow, SBC with C=0
    run(4'd1, 1, 1, 64'd9, 64'd9, 4'b0000, 0, 0, "R2 equal");
    run(4'd1, 1, 1, 64'd3, 64'd9, 4'b0000, 0, 0, "R2 borrow");
    run(4'd3, 1, 1, 64'd10, 64'd3, 4'b0000, 0, 0, "R2 sbc c=0");
    // R3
    run(4'd4, 1, 1, 0, 64'h8000_0000_0000_0000, 4'b0000, 0, 0, "R3 neg min");
    run(4'd5, 1, 1, 0, 64'd7, 4'b0010, 0, 0, "R3 ngc");
    // R4 compare writes flags with sf=0
    run(4'd6, 1, 0, 64'd4, 64'd4, 4'b0000, 0, 0, "R4 cmp eq");
    run(4'd7, 0, 0, 64'd1, 64'hFFFF_FFFF, 4'b1111, 0, 0, "R4 cmn narrow");
    // R5 narrow with dirty upper bits
    run(4'd0, 0, 1, 64'hDEAD_BEEF_FFFF_FFFF, 64'hAAAA_0000_0000_0001, 4'b0000, 0, 0, "R5 carry31");
    run(4'd0, 0, 1, 64'h1_7FFF_FFFF, 64'd1, 4'b0000, 0, 0, "R5 ovf31");
    // R7 flags held
    run(4'd1, 1, 0, 64'd1, 64'd2, 4'b1010, 0, 0, "R7 hold");
    // R8 negative offset, width/sf ignored
    run(4'd8, 0, 1, 0, 0, 4'b0101, 64'h1000, 33'h1F_FFFF, "R8 back");
    run(4'd8, 1, 0, 0, 0, 4'b0000, 64'h2_0000, 33'h0F_FFFF, "R8 fwd");
    // R9 low imm bits ignored, low pc bits cleared
    run(4'd9, 1, 1, 0, 0, 4'b1001, 64'h1234_5678, 33'h0_0000_1FFF, "R9 fwd");
    run(4'd9, 1, 1, 0, 0, 4'b0000, 64'h1234_5678, 33'h1_FFFF_F000, "R9 back");
    // R10 reserved codes
    for (int c = 10; c < 16; c++)
      run(4'(c), 1, 1, 64'd5, 64'd5, 4'b0110, 64'h40, 33'd8, "R10 rsvd");
    // random sweep over all codes and modes
    for (int k = 0; k < 3000; k++)
      run(4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom),
          (k % 7 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom},
          (k % 5 == 0) ? 64'd0 : {$urandom, $urandom}, 4'($urandom),
          {$urandom, $urandom}, 33'({$urandom, $urandom}), "random");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule